// File: doc/BRIEF.md
# Priority Interrupt Controller with Held Requests

This block gathers interrupt requests from up to 64 sources and picks which one the processor should take next. Each source has three bits of state: an enable bit, a held bit and a pending bit. A request always sets the held bit. It also sets the pending bit if the source is enabled when the request arrives. If a source is enabled while its held bit is set, it becomes pending straight away.

Every source has an 8-bit priority, where a smaller value means more urgent. The arbiter reports the most urgent pending source, but only if it outranks the level the processor is currently servicing. Separately, a wake pulse tells an idle processor that something has arrived. A wake is raised even for a masked source. A global lock suppresses both the wake pulses and the arbitration result. A dedicated hard request can force a single wake through the lock.

Software drives a simple command port. One command is accepted per cycle, selected by a 3-bit code. The commands enable or disable a source, write a priority, clear one source, clear all enabled state, clear everything, set or release the lock, or set the current running level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `win_valid` and `wake` are 0, every priority is 255, every enable is 0, the current running level is 256 (idle) and the lock is released.
- R2: A request on source i (`req_valid`, `req_idx`=i<64) always sets the held bit of i. It sets the pending bit of i only if i is enabled in that cycle, so a pending bit is never set without its held bit.
- R3: Command 0 (enable, `ctl_idx`=i) sets the enable bit of i. If the held bit of i is set, the command also sets the pending bit of i and, when unlocked, pulses `wake` one cycle later.
- R4: Command 1 (disable) clears only the enable bit. A pending source stays pending and can still win arbitration.
- R5: Command 3 clears the pending and held bits of source `ctl_idx`. Command 4 clears every pending bit, and clears the held bits of the enabled sources only. Command 5 clears all pending and all held bits.
- R6: The winner is the pending source with the smallest priority value, taking the lowest index on a tie. It must have a priority value strictly below the current running level. Command 2 writes `ctl_data[7:0]` as the priority of `ctl_idx`. Command 7 sets the level to `ctl_data[8:0]`.
- R7: Command 6 sets the lock to `ctl_data[0]`. While the lock is set, `win_valid` is 0 and requests produce no `wake`.
- R8: When the controller is unlocked, a request pulses `wake` one cycle later, even if the source is disabled.
- R9: A command 6 that changes the lock from 1 to 0 while any pending bit is set pulses `wake` one cycle later.
- R10: `hard_req` pulses `wake` one cycle later whatever the lock state. The bypass covers only that one wake, so a later locked request produces no wake.
- R11: A request and a command in the same cycle take effect request first, then command. `win_valid`/`win_id` reflect the state one cycle after that state was written.
- R12: A request with `req_idx` of 64 or more changes no state and produces no wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_idx | input | 7 | Requesting source index (64 and above ignored) |
| hard_req | input | 1 | Hard request that bypasses the lock for one wake |
| ctl_valid | input | 1 | Command strobe |
| ctl_op | input | 3 | Command code (0..7, see R3 to R7) |
| ctl_idx | input | 6 | Source addressed by the command |
| ctl_data | input | 9 | Priority, level or lock value |
| win_valid | output | 1 | A source qualifies for service |
| win_id | output | 6 | Index of the winning source (0 when none) |
| wake | output | 1 | One-cycle wake pulse |

## Verification
The assertions assume that every input is two-valued and stable across the sampling edge. They also assume that `hard_req`, a command and a request may coincide in any mix, with no protocol ordering between them. The stimulus drives every field from `$urandom` with a fixed seed, or from directed values, always at the falling edge. Request indices are biased to stay in range but sometimes go above 63. Priorities are drawn from a small set so that ties are common. The lock toggles often enough that the locked-request, unlock and hard-bypass paths are all exercised.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_ENABLE    = 3'd0,
    OP_DISABLE   = 3'd1,
    OP_SET_PRIO  = 3'd2,
    OP_CLR_ONE   = 3'd3,
    OP_CLR_EN    = 3'd4,
    OP_CLR_ALL   = 3'd5,
    OP_SET_LOCK  = 3'd6,
    OP_SET_LEVEL = 3'd7
  } ctl_op_e;
endpackage

// File: rtl/ipc_src_bank.sv
// Per-source enable / held / pending state, lock and wake generation.
module ipc_src_bank
  import ipc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = $clog2(NUM_SRC),
  parameter int REQ_W   = ID_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [REQ_W-1:0]   req_idx,
  input  logic               hard_req,
  input  logic               ctl_valid,
  input  logic [2:0]         ctl_op,
  input  logic [ID_W-1:0]    ctl_idx,
  input  logic               ctl_lock_bit,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] premask_q,
  output logic [NUM_SRC-1:0] enable_q,
  output logic               lock_q,
  output logic               wake_q
);
  localparam logic [REQ_W-1:0] SRC_LIMIT = REQ_W'(NUM_SRC);

  logic               req_hit;
  logic [NUM_SRC-1:0] req_hot, ctl_hot;
  logic [NUM_SRC-1:0] st_n, pm_n, en_n;
  logic               lock_n, wake_n;

  always_comb begin
    req_hit = req_valid && (req_idx < SRC_LIMIT);
    req_hot = req_hit ? (NUM_SRC'(1) << req_idx[ID_W-1:0]) : '0;
    ctl_hot = NUM_SRC'(1) << ctl_idx;
    // request stage first
    pm_n    = premask_q | req_hot;
    st_n    = status_q | (req_hot & enable_q);
    en_n    = enable_q;
    lock_n  = lock_q;
    wake_n  = (req_hit && !lock_q) || hard_req;
    // command stage second
    if (ctl_valid) begin
      case (ctl_op_e'(ctl_op))
        OP_ENABLE: begin
          en_n = en_n | ctl_hot;
          if (|(pm_n & ctl_hot)) begin
            st_n = st_n | ctl_hot;
            if (!lock_q) wake_n = 1'b1;
          end
        end
        OP_DISABLE: en_n = en_n & ~ctl_hot;
        OP_CLR_ONE: begin
          st_n = st_n & ~ctl_hot;
          pm_n = pm_n & ~ctl_hot;
        end
        OP_CLR_EN: begin
          st_n = '0;
          pm_n = pm_n & ~enable_q;
        end
        OP_CLR_ALL: begin
          st_n = '0;
          pm_n = '0;
        end
        OP_SET_LOCK: begin
          lock_n = ctl_lock_bit;
          if (lock_q && !ctl_lock_bit && (|st_n)) wake_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      premask_q <= '0;
      enable_q  <= '0;
      lock_q    <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      status_q  <= st_n;
      premask_q <= pm_n;
      enable_q  <= en_n;
      lock_q    <= lock_n;
      wake_q    <= wake_n;
    end
  end
endmodule

// File: rtl/ipc_prio_table.sv
// Per-source priority registers, all readable in parallel.
module ipc_prio_table #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ID_W-1:0]           wr_idx,
  input  logic [PRIO_W-1:0]         wr_data,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
    logic [PRIO_W-1:0] prio_q;
    always_ff @(posedge clk) begin
      if (rst)                                 prio_q <= '1;
      else if (wr_en && wr_idx == ID_W'(g))    prio_q <= wr_data;
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
  end
endmodule

// File: rtl/ipc_arb_tree.sv
// Binary min-priority tree; on equal priority the lower-index branch is kept.
module ipc_arb_tree #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = $clog2(NUM_SRC),
  parameter int LVL_W   = PRIO_W + 1
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [LVL_W-1:0]          level,
  output logic                      any,
  output logic [ID_W-1:0]           best_id
);
  localparam int LEAVES = 1 << ID_W;
  localparam int NODES  = 2 * LEAVES;

  logic              node_v  [1:NODES-1];
  logic [PRIO_W-1:0] node_p  [1:NODES-1];
  logic [ID_W-1:0]   node_id [1:NODES-1];

  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    if (g < NUM_SRC) begin : g_real
      logic [PRIO_W-1:0] p;
      assign p                  = prio_flat[g*PRIO_W +: PRIO_W];
      assign node_v[LEAVES+g]   = cand[g] && ({1'b0, p} < level);
      assign node_p[LEAVES+g]   = p;
      assign node_id[LEAVES+g]  = ID_W'(g);
    end else begin : g_pad
      assign node_v[LEAVES+g]   = 1'b0;
      assign node_p[LEAVES+g]   = '1;
      assign node_id[LEAVES+g]  = '0;
    end
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic take_r;
    assign take_r = node_v[2*n+1] &&
                    (!node_v[2*n] || (node_p[2*n+1] < node_p[2*n]));
    assign node_v[n]  = node_v[2*n] || node_v[2*n+1];
    assign node_p[n]  = take_r ? node_p[2*n+1]  : node_p[2*n];
    assign node_id[n] = take_r ? node_id[2*n+1] : node_id[2*n];
  end

  assign any     = node_v[1];
  assign best_id = node_id[1];
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import ipc_pkg::*;
#(
  parameter  int NUM_SRC = 64,
  parameter  int PRIO_W  = 8,
  localparam int ID_W    = $clog2(NUM_SRC),
  localparam int LVL_W   = PRIO_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [ID_W:0]    req_idx,
  input  logic             hard_req,
  input  logic             ctl_valid,
  input  logic [2:0]       ctl_op,
  input  logic [ID_W-1:0]  ctl_idx,
  input  logic [LVL_W-1:0] ctl_data,
  output logic             win_valid,
  output logic [ID_W-1:0]  win_id,
  output logic             wake
);
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(1) << PRIO_W;

  logic [NUM_SRC-1:0]        status_q, premask_q, enable_q;
  logic                      lock_q;
  logic [LVL_W-1:0]          level_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      arb_any;
  logic [ID_W-1:0]           arb_id;

  ipc_src_bank #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .REQ_W(ID_W+1)) bank_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_idx(req_idx), .hard_req(hard_req),
    .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_idx(ctl_idx),
    .ctl_lock_bit(ctl_data[0]),
    .status_q(status_q), .premask_q(premask_q), .enable_q(enable_q),
    .lock_q(lock_q), .wake_q(wake)
  );

  ipc_prio_table #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) prio_i (
    .clk(clk), .rst(rst),
    .wr_en(ctl_valid && (ctl_op_e'(ctl_op) == OP_SET_PRIO)),
    .wr_idx(ctl_idx), .wr_data(ctl_data[PRIO_W-1:0]),
    .prio_flat(prio_flat)
  );

  ipc_arb_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W), .LVL_W(LVL_W)) arb_i (
    .cand(status_q), .prio_flat(prio_flat), .level(level_q),
    .any(arb_any), .best_id(arb_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q   <= LVL_IDLE;
      win_valid <= 1'b0;
      win_id    <= '0;
    end else begin
      if (ctl_valid && (ctl_op_e'(ctl_op) == OP_SET_LEVEL)) level_q <= ctl_data;
      win_valid <= arb_any && !lock_q;
      win_id    <= (arb_any && !lock_q) ? arb_id : '0;
    end
  end
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ID_W:0]      req_idx,
  input logic               hard_req,
  input logic               ctl_valid,
  input logic [2:0]         ctl_op,
  input logic [ID_W-1:0]    ctl_idx,
  input logic               win_valid,
  input logic [ID_W-1:0]    win_id,
  input logic               wake,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] premask_q,
  input logic [NUM_SRC-1:0] enable_q,
  input logic               lock_q
);
  localparam logic [ID_W:0] SRC_LIMIT = (ID_W+1)'(NUM_SRC);

  AST_PENDING_HAS_HELD: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~premask_q) == '0); // R2

  AST_DISABLE_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
    (ctl_valid && ctl_op == 3'd1) |=>
      ((enable_q >> $past(ctl_idx)) & NUM_SRC'(1)) == '0); // R4

  AST_CLEAR_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ctl_valid && ctl_op == 3'd5) |=> (status_q == '0 && premask_q == '0)); // R5

  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (($past(status_q) >> win_id) & NUM_SRC'(1)) != '0); // R6

  AST_WIN_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !$past(lock_q)); // R7

  AST_LOCK_MUTES_WAKE: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !hard_req && !(ctl_valid && ctl_op == 3'd6)) |=> !wake); // R7

  AST_HARD_WAKES: assert property (@(posedge clk) disable iff (rst)
    hard_req |=> wake); // R10

  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_idx >= SRC_LIMIT && !hard_req && !ctl_valid) |=>
      (!wake && $stable(premask_q) && $stable(status_q))); // R12
endmodule

bind irq_prio_ctrl ipc_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
  .hard_req(hard_req), .ctl_valid(ctl_valid), .ctl_op(ctl_op),
  .ctl_idx(ctl_idx), .win_valid(win_valid), .win_id(win_id), .wake(wake),
  .status_q(status_q), .premask_q(premask_q), .enable_q(enable_q),
  .lock_q(lock_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  localparam int N = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 0, hard_req = 0, ctl_valid = 0;
  logic [6:0] req_idx = '0;
  logic [2:0] ctl_op = '0;
  logic [5:0] ctl_idx = '0;
  logic [8:0] ctl_data = '0;
  logic       win_valid, wake;
  logic [5:0] win_id;

  int n_checks = 0;
  int n_fail   = 0;

  bit [N-1:0] m_en, m_pm, m_st;
  int         m_prio [N];
  int         m_level;
  bit         m_lock;

  always #4 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .hard_req(hard_req), .ctl_valid(ctl_valid), .ctl_op(ctl_op),
    .ctl_idx(ctl_idx), .ctl_data(ctl_data),
    .win_valid(win_valid), .win_id(win_id), .wake(wake)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_pm = '0; m_st = '0;
    for (int i = 0; i < N; i++) m_prio[i] = 255;
    m_level = 256;
    m_lock  = 1'b0;
  endtask

  function automatic void model_arb(output bit v, output int id);
    int best = 256;
    v = 1'b0; id = 0;
    if (m_lock) return;
    for (int i = 0; i < N; i++)
      if (m_st[i] && m_prio[i] < best && m_prio[i] < m_level) begin
        best = m_prio[i]; id = i; v = 1'b1;
      end
  endfunction

  // Called just after a falling edge; drives one cycle and checks the results.
  task automatic cyc(input bit rv, input int ri, input bit hr, input bit cv,
                     input int op, input int ci, input int cd, input string tag);
    bit ev; int eid; bit ew; bit hit; bit old_lock;
    req_valid = rv; req_idx = 7'(ri); hard_req = hr;
    ctl_valid = cv; ctl_op = 3'(op); ctl_idx = 6'(ci); ctl_data = 9'(cd);
    model_arb(ev, eid);
    old_lock = m_lock;
    hit = rv && ri < N;
    ew  = (hit && !old_lock) || hr;
    if (hit) begin
      m_pm[ri] = 1'b1;
      if (m_en[ri]) m_st[ri] = 1'b1;
    end
    if (cv) begin
      case (op)
        0: begin
          m_en[ci] = 1'b1;
          if (m_pm[ci]) begin m_st[ci] = 1'b1; if (!old_lock) ew = 1'b1; end
        end
        1: m_en[ci] = 1'b0;
        2: m_prio[ci] = cd & 255;
        3: begin m_st[ci] = 1'b0; m_pm[ci] = 1'b0; end
        4: begin m_st = '0; m_pm = m_pm & ~m_en; end
        5: begin m_st = '0; m_pm = '0; end
        6: begin
          m_lock = cd[0];
          if (old_lock && !cd[0] && m_st != '0) ew = 1'b1;
        end
        default: m_level = cd & 511;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    chk(wake == ew, tag, "wake", int'(wake), int'(ew));
    chk(win_valid == ev, tag, "win_valid", int'(win_valid), int'(ev));
    if (ev) chk(int'(win_id) == eid, tag, "win_id", int'(win_id), eid);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(win_valid == 1'b0, "R1", "win_valid after reset", int'(win_valid), 0);
    chk(wake == 1'b0, "R1", "wake after reset", int'(wake), 0);
    idle("R1");

    // masked request still wakes; enable raises held source; default prio 255 wins at idle level
    cyc(1, 5, 0, 0, 0, 0, 0, "R8");
    idle("R2");
    cyc(0, 0, 0, 1, 0, 5, 0, "R3");
    idle("R1");
    idle("R1");

    // arbitration, tie on priority, strict level compare
    cyc(0, 0, 0, 1, 2, 20, 3, "R6");
    cyc(0, 0, 0, 1, 2, 7, 3, "R6");
    cyc(0, 0, 0, 1, 0, 20, 0, "R6");
    cyc(0, 0, 0, 1, 0, 7, 0, "R6");
    cyc(1, 20, 0, 0, 0, 0, 0, "R6");
    cyc(1, 7, 0, 0, 0, 0, 0, "R6");
    idle("R6");
    cyc(0, 0, 0, 1, 7, 0, 3, "R6");
    idle("R6");
    idle("R6");
    cyc(0, 0, 0, 1, 7, 0, 4, "R6");
    idle("R6");
    idle("R6");

    // disable keeps pending
    cyc(0, 0, 0, 1, 1, 7, 0, "R4");
    idle("R4");
    idle("R4");

    // clears
    cyc(0, 0, 0, 1, 3, 7, 0, "R5");
    idle("R5");
    idle("R5");
    cyc(0, 0, 0, 1, 0, 7, 0, "R5");
    cyc(1, 9, 0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 4, 0, 0, "R5");
    idle("R5");
    cyc(0, 0, 0, 1, 0, 9, 0, "R5");
    cyc(0, 0, 0, 1, 1, 9, 0, "R5");
    cyc(1, 40, 0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 1, 5, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, 40, 0, "R5");
    idle("R5");

    // lock, unlock wake, hard bypass
    cyc(0, 0, 0, 1, 7, 0, 256, "R7");
    cyc(0, 0, 0, 1, 6, 0, 1, "R7");
    cyc(1, 20, 0, 0, 0, 0, 0, "R7");
    idle("R7");
    cyc(0, 0, 1, 0, 0, 0, 0, "R10");
    cyc(1, 7, 0, 0, 0, 0, 0, "R10");
    idle("R10");
    cyc(0, 0, 0, 1, 6, 0, 0, "R9");
    idle("R9");

    // ordering of request and command in one cycle
    cyc(0, 0, 0, 1, 0, 30, 0, "R11");
    cyc(1, 30, 0, 1, 3, 30, 0, "R11");
    idle("R11");
    cyc(1, 31, 0, 1, 0, 31, 0, "R11");
    idle("R11");

    // out-of-range requests
    cyc(0, 0, 0, 1, 5, 0, 0, "R12");
    cyc(1, 64, 0, 0, 0, 0, 0, "R12");
    cyc(1, 127, 0, 0, 0, 0, 0, "R12");
    cyc(0, 0, 0, 1, 0, 0, 0, "R12");
    cyc(0, 0, 0, 1, 0, 63, 0, "R12");
    idle("R12");

    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      bit rv = ($urandom % 3) == 0;
      int ri = (($urandom % 10) == 0) ? 64 + ($urandom % 64) : ($urandom % 16);
      bit hr = ($urandom % 40) == 0;
      bit cv = ($urandom % 2) == 0;
      int op = $urandom % 8;
      int ci = $urandom % 16;
      int cd;
      if (op == 2)      cd = $urandom % 6;
      else if (op == 7) cd = (($urandom % 4) == 0) ? 256 : ($urandom % 7);
      else              cd = $urandom % 2;
      if (op == 5 && ($urandom % 4) != 0) op = 0;
      cyc(rv, ri, hr, cv, op, ci, cd, "R11");
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule